// File: doc/BRIEF.md
# Instruction Pair Fusion Detector

This block sits in the decode stage of a two-operand processor core. Each cycle it looks at a window of up to three instruction slots, already aligned by the predecoder. It decides whether the first two can be collapsed into one operation for a single ALU. The pattern it collapses is a preload of a data register followed by an ALU operation of the form `OP <ea>,Dn` that writes the same register. The preload can be a quick 8-bit immediate, a long register move or a long 32-bit immediate move. The fused descriptor takes its first ALU operand from the preload source and its second from the effective address of the ALU instruction, and it writes the shared destination register.

Some pairs are not fused but are marked for the forwarding network. The first is an ALU result followed by a store of that register. The second is a memory load followed by an operation that reads the loaded register and writes memory. When a pair fuses and the third slot stores the fused destination, the block reports the fusion and the store mark together. All outputs are registered, one cycle after the window is presented.

Top module: `fusion_detector`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, every output is zero.
- R2: A quick load `0111 rrr 0 iiiiiiii` followed by a long ALU `<ea>,Dn` on the same `rrr` fuses: `fuse_o`=1, `slots_o`=2, `a_imm_sel_o`=1, and `a_imm_o` is the 8-bit immediate sign-extended to 32 bits.
- R3: A long register move `0010 ddd 000 000 sss` followed by a long ALU `<ea>,Dd` fuses with `a_imm_sel_o`=0 and `a_reg_o`=`sss`.
- R4: A long immediate move `0010 ddd 000 111 100` followed by a long ALU `<ea>,Dd` fuses with `a_imm_sel_o`=1 and `a_imm_o`={`ext_hi_i`,`ext_lo_i`}.
- R5: The second instruction is a long ALU `<ea>,Dn` when bits [8:6]=010 and bits [15:12] are 1101 (add, `op_o`=1), 1001 (sub, 2), 1100 (and, 3), 1000 (or, 4) or 1011 (eor, 5). Any other top nibble blocks fusion, and `op_o` is 0 whenever no fusion happens.
- R6: Fusion needs the two register fields [11:9] to be equal, and the second instruction's ea must not be data register Dn itself (mode 000 with register Dn). The fused `dst_o` is that register, and `ea_mode_o`/`ea_reg_o` are bits [5:3]/[2:0] of the second word.
- R7: With `val0_i` low, `slots_o`=0 and `raw_o`=0. With `val0_i` high and no fusion (including `val1_i` low), `slots_o`=1 and `fuse_o`=0. With `val0_i` high, `raw_o` echoes the first word.
- R8: When slot 0 is an unfused long ALU `<ea>,Dn` and slot 1 is a long store `0010 rrr mmm 000 nnn` of Dn (`nnn`=n) whose destination mode `mmm` is memory (010 to 110, or 111 with `rrr` 000 or 001), `wr_fwd_o`=1.
- R9: When slots 0 and 1 fuse and a valid slot 2 stores the fused destination register to memory as in R8, `fuse_o` and `wr_fwd_o` are both 1.
- R10: A long load `0010 ddd 000 mmm sss` with a memory source (modes 010 to 110, or 111 with `sss` from 000 to 011) followed by a long ALU `Dd,<ea>` (bits [8:6]=110, memory ea) on the same `ddd` sets `rd_fwd_o`=1 and `fuse_o`=0.
- R11: Outputs change only at a rising clock edge and reflect the window presented before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins0_i | input | 16 | First instruction word of the window |
| ins1_i | input | 16 | Second instruction word |
| ins2_i | input | 16 | Third instruction word |
| val0_i | input | 1 | Slot 0 holds an instruction |
| val1_i | input | 1 | Slot 1 holds an instruction |
| val2_i | input | 1 | Slot 2 holds an instruction |
| ext_hi_i | input | 16 | Upper extension word following slot 0 |
| ext_lo_i | input | 16 | Lower extension word following slot 0 |
| fuse_o | output | 1 | Slots 0 and 1 were merged |
| slots_o | output | 2 | Number of slots consumed |
| op_o | output | 3 | Fused ALU operation code |
| a_imm_sel_o | output | 1 | First operand is an immediate |
| a_reg_o | output | 3 | First operand register when not immediate |
| a_imm_o | output | 32 | First operand immediate |
| ea_mode_o | output | 3 | Second operand ea mode |
| ea_reg_o | output | 3 | Second operand ea register |
| dst_o | output | 3 | Destination data register |
| raw_o | output | 16 | First instruction word passed through |
| wr_fwd_o | output | 1 | Following store is a result-forwarding candidate |
| rd_fwd_o | output | 1 | Load-then-operate pair needs read-result forwarding |

## Verification
Fusion and the store-forwarding mark can appear in the same cycle, when a preload, a matching ALU operation and a store of the same register fill all three slots. The bench builds this case directly. It also reaches it by random generation, which often reuses one register number across the slots. It then checks that `fuse_o`, `slots_o`=2 and `wr_fwd_o` all come out in the same registered cycle. A store whose source register differs by one, placed in the third slot, must leave the fusion in place and clear the mark.

// File: rtl/fdet_pkg.sv
// Package: shared widths, operation codes and record types of the fusion detector.
// Assumes 16-bit instruction words and eight data registers.
package fdet_pkg;
    parameter int INSN_W  = 16;
    parameter int REG_W   = 3;
    parameter int DATA_W  = 32;
    parameter int NSLOT   = 3;
    parameter int IMMQ_W  = 8;
    localparam int EXT_W  = DATA_W / 2;
    localparam int CNT_W  = $clog2(NSLOT + 1);

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_ADD  = 3'd1,
        OP_SUB  = 3'd2,
        OP_AND  = 3'd3,
        OP_OR   = 3'd4,
        OP_EOR  = 3'd5
    } alu_op_e;

    // Per-slot classification produced by the slot decoder.
    typedef struct packed {
        logic              pre_q;      // quick immediate load
        logic              pre_r;      // long register move
        logic              pre_i;      // long immediate move
        logic              alu_ea_dn;  // OP <ea>,Dn long
        logic              alu_dn_ea;  // OP Dn,<mem> long
        logic              store;      // move Dn to memory
        logic              load;       // move memory to Dn
        logic [REG_W-1:0]  dreg;       // register field [11:9]
        logic [REG_W-1:0]  src_reg;    // low register field [2:0]
        logic [2:0]        ea_mode;    // mode field [5:3]
        alu_op_e           op;
        logic [IMMQ_W-1:0] imm8;
    } slot_info_t;

    // Registered result of the detector.
    typedef struct packed {
        logic              fuse;
        logic [CNT_W-1:0]  slots;
        alu_op_e           op;
        logic              asel;
        logic [REG_W-1:0]  areg;
        logic [DATA_W-1:0] aimm;
        logic [2:0]        eam;
        logic [REG_W-1:0]  ear;
        logic [REG_W-1:0]  dst;
        logic [INSN_W-1:0] raw;
        logic              wf;
        logic              rf;
    } fuse_out_t;
endpackage

// File: rtl/fdet_slot_decode.sv
// Module: classifies one instruction word into the few shapes the fusion
// detector cares about. Purely combinational; assumes the word is aligned.
module fdet_slot_decode
    import fdet_pkg::*;
(
    input  logic [INSN_W-1:0] word_i,
    output slot_info_t        info_o
);
    logic [3:0] opc;
    logic [2:0] hi_reg, hi_mode, lo_mode, lo_reg;
    logic       is_move, src_mem, dst_mem, ea_alterable;
    alu_op_e    op_w;

    assign opc     = word_i[15:12];
    assign hi_reg  = word_i[11:9];
    assign hi_mode = word_i[8:6];
    assign lo_mode = word_i[5:3];
    assign lo_reg  = word_i[2:0];
    assign is_move = (opc == 4'b0010);

    // Map the top nibble to a supported ALU operation.
    always_comb begin
        unique case (opc)
            4'b1101: op_w = OP_ADD;
            4'b1001: op_w = OP_SUB;
            4'b1100: op_w = OP_AND;
            4'b1000: op_w = OP_OR;
            4'b1011: op_w = OP_EOR;
            default: op_w = OP_NONE;
        endcase
    end

    // Memory-class tests on the source and destination ea fields.
    always_comb begin
        src_mem      = ((lo_mode >= 3'd2) && (lo_mode <= 3'd6)) ||
                       ((lo_mode == 3'd7) && (lo_reg <= 3'd3));
        dst_mem      = ((hi_mode >= 3'd2) && (hi_mode <= 3'd6)) ||
                       ((hi_mode == 3'd7) && (hi_reg <= 3'd1));
        ea_alterable = ((lo_mode >= 3'd2) && (lo_mode <= 3'd6)) ||
                       ((lo_mode == 3'd7) && (lo_reg <= 3'd1));
    end

    // Assemble the classification record.
    always_comb begin
        info_o           = '0;
        info_o.op        = op_w;
        info_o.pre_q     = (opc == 4'b0111) && !word_i[8];
        info_o.pre_r     = is_move && (hi_mode == 3'd0) && (lo_mode == 3'd0);
        info_o.pre_i     = is_move && (hi_mode == 3'd0) && (lo_mode == 3'd7) &&
                           (lo_reg == 3'd4);
        info_o.load      = is_move && (hi_mode == 3'd0) && src_mem;
        info_o.store     = is_move && (lo_mode == 3'd0) && dst_mem;
        info_o.alu_ea_dn = (op_w != OP_NONE) && (hi_mode == 3'b010);
        info_o.alu_dn_ea = (op_w != OP_NONE) && (hi_mode == 3'b110) && ea_alterable;
        info_o.dreg      = hi_reg;
        info_o.src_reg   = lo_reg;
        info_o.ea_mode   = lo_mode;
        info_o.imm8      = word_i[IMMQ_W-1:0];
    end
endmodule

// File: rtl/fdet_pair_match.sv
// Module: matches classified slots against the fusible and forwarding
// patterns and builds the next descriptor. Combinational; assumes slot 0 is
// the oldest instruction of the window.
module fdet_pair_match
    import fdet_pkg::*;
(
    input  slot_info_t        s0_i,
    input  slot_info_t        s1_i,
    input  slot_info_t        s2_i,
    input  logic [NSLOT-1:0]  val_i,
    input  logic [INSN_W-1:0] ins0_i,
    input  logic [EXT_W-1:0]  ext_hi_i,
    input  logic [EXT_W-1:0]  ext_lo_i,
    output fuse_out_t         out_o
);
    logic is_pre, same_reg, ea_self, can_fuse;
    logic st_after_fuse, st_after_alu, ld_then_op;

    // Pattern conditions over the first two slots.
    always_comb begin
        is_pre   = s0_i.pre_q || s0_i.pre_r || s0_i.pre_i;
        same_reg = (s0_i.dreg == s1_i.dreg);
        ea_self  = (s1_i.ea_mode == 3'd0) && (s1_i.src_reg == s1_i.dreg);
        can_fuse = val_i[0] && val_i[1] && is_pre && s1_i.alu_ea_dn &&
                   same_reg && !ea_self;
    end

    // Forwarding candidates, fused or not.
    always_comb begin
        st_after_fuse = val_i[2] && s2_i.store && (s2_i.src_reg == s1_i.dreg);
        st_after_alu  = val_i[0] && val_i[1] && s0_i.alu_ea_dn && s1_i.store &&
                        (s1_i.src_reg == s0_i.dreg);
        ld_then_op    = val_i[0] && val_i[1] && s0_i.load && s1_i.alu_dn_ea &&
                        same_reg;
    end

    // Build the descriptor for the next register stage.
    always_comb begin
        out_o    = '0;
        out_o.op = OP_NONE;
        if (val_i[0]) begin
            out_o.raw   = ins0_i;
            out_o.slots = CNT_W'(1);
        end
        if (can_fuse) begin
            out_o.fuse  = 1'b1;
            out_o.slots = CNT_W'(2);
            out_o.op    = s1_i.op;
            out_o.asel  = !s0_i.pre_r;
            out_o.areg  = s0_i.pre_r ? s0_i.src_reg : '0;
            if (s0_i.pre_q)
                out_o.aimm = {{(DATA_W-IMMQ_W){s0_i.imm8[IMMQ_W-1]}}, s0_i.imm8};
            else if (s0_i.pre_i)
                out_o.aimm = {ext_hi_i, ext_lo_i};
            out_o.eam   = s1_i.ea_mode;
            out_o.ear   = s1_i.src_reg;
            out_o.dst   = s1_i.dreg;
            out_o.wf    = st_after_fuse;
        end else begin
            out_o.wf    = st_after_alu;
            out_o.rf    = ld_then_op;
        end
    end
endmodule

// File: rtl/fusion_detector.sv
// Module: top of the instruction pair fusion detector. Decodes each window
// slot, matches the pair patterns and registers the descriptor one cycle
// later. Assumes a synchronous active-low reset.
module fusion_detector
    import fdet_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] ins0_i,
    input  logic [15:0] ins1_i,
    input  logic [15:0] ins2_i,
    input  logic        val0_i,
    input  logic        val1_i,
    input  logic        val2_i,
    input  logic [15:0] ext_hi_i,
    input  logic [15:0] ext_lo_i,
    output logic        fuse_o,
    output logic [1:0]  slots_o,
    output logic [2:0]  op_o,
    output logic        a_imm_sel_o,
    output logic [2:0]  a_reg_o,
    output logic [31:0] a_imm_o,
    output logic [2:0]  ea_mode_o,
    output logic [2:0]  ea_reg_o,
    output logic [2:0]  dst_o,
    output logic [15:0] raw_o,
    output logic        wr_fwd_o,
    output logic        rd_fwd_o
);
    logic [INSN_W-1:0] words [NSLOT];
    slot_info_t        info  [NSLOT];
    logic [NSLOT-1:0]  valid;
    fuse_out_t         nxt, q;

    assign words[0] = ins0_i;
    assign words[1] = ins1_i;
    assign words[2] = ins2_i;
    assign valid    = {val2_i, val1_i, val0_i};

    // One classifier per window slot.
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        fdet_slot_decode u_dec (
            .word_i (words[g]),
            .info_o (info[g])
        );
    end

    fdet_pair_match u_match (
        .s0_i     (info[0]),
        .s1_i     (info[1]),
        .s2_i     (info[2]),
        .val_i    (valid),
        .ins0_i   (ins0_i),
        .ext_hi_i (ext_hi_i),
        .ext_lo_i (ext_lo_i),
        .out_o    (nxt)
    );

    // Output register stage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    assign fuse_o      = q.fuse;
    assign slots_o     = q.slots;
    assign op_o        = q.op;
    assign a_imm_sel_o = q.asel;
    assign a_reg_o     = q.areg;
    assign a_imm_o     = q.aimm;
    assign ea_mode_o   = q.eam;
    assign ea_reg_o    = q.ear;
    assign dst_o       = q.dst;
    assign raw_o       = q.raw;
    assign wr_fwd_o    = q.wf;
    assign rd_fwd_o    = q.rf;
endmodule

// File: rtl/fusion_detector_chk.sv
// Module: property checker for the fusion detector, bound to its top.
// Assumes the one-cycle registered timing of the outputs.
module fusion_detector_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] ins0_i,
    input logic [15:0] ins1_i,
    input logic        val0_i,
    input logic        fuse_o,
    input logic [1:0]  slots_o,
    input logic [2:0]  op_o,
    input logic [2:0]  dst_o,
    input logic [31:0] a_imm_o,
    input logic [15:0] raw_o,
    input logic        rd_fwd_o
);
    logic primed;

    // Marks cycles whose outputs came from a window seen out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    p_fuse_two_slots_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_o |-> slots_o == 2'd2);

    p_unfused_one_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(val0_i) && !fuse_o |-> slots_o == 2'd1);

    p_empty_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        primed && !$past(val0_i) |-> slots_o == 2'd0 && !fuse_o && raw_o == 16'd0);

    p_read_fwd_unfused_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fwd_o |-> !fuse_o);

    p_fused_op_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_o |-> (op_o >= 3'd1) && (op_o <= 3'd5));

    p_unfused_no_op_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !fuse_o |-> op_o == 3'd0);

    p_dst_shared_r6: assert property (@(posedge clk) disable iff (!rst_n)
        primed && fuse_o |-> dst_o == $past(ins1_i[11:9]) && dst_o == $past(ins0_i[11:9]));

    p_quick_sext_r2: assert property (@(posedge clk) disable iff (!rst_n)
        primed && fuse_o && $past(ins0_i[15:12]) == 4'b0111 |->
        a_imm_o == {{24{$past(ins0_i[7])}}, $past(ins0_i[7:0])});

    p_raw_echo_r11: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(val0_i) |-> raw_o == $past(ins0_i));
endmodule

bind fusion_detector fusion_detector_chk chk_i (.*);

// File: tb/fusion_detector_tb_top.sv
module fusion_detector_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ins0_i = '0, ins1_i = '0, ins2_i = '0;
    logic        val0_i = 1'b0, val1_i = 1'b0, val2_i = 1'b0;
    logic [15:0] ext_hi_i = '0, ext_lo_i = '0;
    logic        fuse_o, a_imm_sel_o, wr_fwd_o, rd_fwd_o;
    logic [1:0]  slots_o;
    logic [2:0]  op_o, a_reg_o, ea_mode_o, ea_reg_o, dst_o;
    logic [31:0] a_imm_o;
    logic [15:0] raw_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct packed {
        logic        fuse;
        logic [1:0]  slots;
        logic [2:0]  op;
        logic        asel;
        logic [2:0]  areg;
        logic [31:0] aimm;
        logic [2:0]  eam;
        logic [2:0]  ear;
        logic [2:0]  dst;
        logic [15:0] raw;
        logic        wf;
        logic        rf;
    } exp_t;

    exp_t prev_exp;

    always #5 clk = ~clk;

    fusion_detector dut_i (.*);

    // Bench-side encoders, written from the requirement encodings.
    function automatic logic [15:0] enc_quick(input logic [2:0] r, input logic [7:0] imm);
        return {4'b0111, r, 1'b0, imm};
    endfunction
    function automatic logic [15:0] enc_mreg(input logic [2:0] d, input logic [2:0] s);
        return {4'b0010, d, 3'b000, 3'b000, s};
    endfunction
    function automatic logic [15:0] enc_mimm(input logic [2:0] d);
        return {4'b0010, d, 3'b000, 3'b111, 3'b100};
    endfunction
    function automatic logic [15:0] enc_alu(input logic [3:0] opn, input logic [2:0] d,
                                            input logic [2:0] om, input logic [2:0] m,
                                            input logic [2:0] r);
        return {opn, d, om, m, r};
    endfunction
    function automatic logic [15:0] enc_store(input logic [2:0] s, input logic [2:0] m,
                                              input logic [2:0] r);
        return {4'b0010, r, m, 3'b000, s};
    endfunction
    function automatic logic [15:0] enc_load(input logic [2:0] d, input logic [2:0] m,
                                             input logic [2:0] r);
        return {4'b0010, d, 3'b000, m, r};
    endfunction

    function automatic logic [2:0] op_code(input logic [3:0] n);
        case (n)
            4'b1101: return 3'd1;
            4'b1001: return 3'd2;
            4'b1100: return 3'd3;
            4'b1000: return 3'd4;
            4'b1011: return 3'd5;
            default: return 3'd0;
        endcase
    endfunction

    function automatic bit st_like(input logic [15:0] w, input logic [2:0] n);
        logic [2:0] m, r;
        m = w[8:6]; r = w[11:9];
        return (w[15:12] == 4'b0010) && (w[5:3] == 3'd0) && (w[2:0] == n) &&
               (((m >= 2) && (m <= 6)) || ((m == 7) && (r <= 1)));
    endfunction

    // Expected outputs computed from the requirements.
    function automatic exp_t model(input logic [15:0] a, b, c, input bit v0, v1, v2,
                                   input logic [15:0] eh, el);
        exp_t e;
        bit q, rr, ri, alu1, ok;
        e = '0;
        if (v0) begin e.raw = a; e.slots = 2'd1; end
        q    = (a[15:12] == 4'b0111) && !a[8];
        rr   = (a[15:12] == 4'b0010) && (a[8:3] == 6'b000000);
        ri   = (a[15:12] == 4'b0010) && (a[8:0] == 9'b000_111_100);
        alu1 = (op_code(b[15:12]) != 0) && (b[8:6] == 3'b010);
        ok   = v0 && v1 && (q || rr || ri) && alu1 && (a[11:9] == b[11:9]) &&
               !((b[5:3] == 3'd0) && (b[2:0] == b[11:9]));
        if (ok) begin
            e.fuse  = 1'b1;
            e.slots = 2'd2;
            e.op    = op_code(b[15:12]);
            e.asel  = !rr;
            e.areg  = rr ? a[2:0] : 3'd0;
            e.aimm  = q ? {{24{a[7]}}, a[7:0]} : (ri ? {eh, el} : 32'd0);
            e.eam   = b[5:3];
            e.ear   = b[2:0];
            e.dst   = b[11:9];
            e.wf    = v2 && st_like(c, b[11:9]);
        end else begin
            e.wf = v0 && v1 && (op_code(a[15:12]) != 0) && (a[8:6] == 3'b010) &&
                   st_like(b, a[11:9]);
            e.rf = v0 && v1 && (a[15:12] == 4'b0010) && (a[8:6] == 3'd0) &&
                   (((a[5:3] >= 2) && (a[5:3] <= 6)) || ((a[5:3] == 7) && (a[2:0] <= 3))) &&
                   (op_code(b[15:12]) != 0) && (b[8:6] == 3'b110) &&
                   (((b[5:3] >= 2) && (b[5:3] <= 6)) || ((b[5:3] == 7) && (b[2:0] <= 1))) &&
                   (a[11:9] == b[11:9]);
        end
        return e;
    endfunction

    function automatic exp_t actual();
        exp_t x;
        x = {fuse_o, slots_o, op_o, a_imm_sel_o, a_reg_o, a_imm_o, ea_mode_o,
             ea_reg_o, dst_o, raw_o, wr_fwd_o, rd_fwd_o};
        return x;
    endfunction

    task automatic compare(input exp_t e, input string tag);
        exp_t x;
        x = actual();
        checks++;
        if (x !== e) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, x, e);
        end
    endtask

    task automatic check_bit(input logic act, input logic expv, input string tag);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, expv);
        end
    endtask

    // Drive one window at a falling edge, check hold and then the result.
    task automatic apply(input logic [15:0] a, b, c, input bit v0, v1, v2,
                         input logic [15:0] eh, el, input string tag);
        exp_t e;
        ins0_i = a; ins1_i = b; ins2_i = c;
        val0_i = v0; val1_i = v1; val2_i = v2;
        ext_hi_i = eh; ext_lo_i = el;
        e = model(a, b, c, v0, v1, v2, eh, el);
        #1;
        compare(prev_exp, "R11 hold before edge");
        @(negedge clk);
        compare(e, tag);
        prev_exp = e;
    endtask

    function automatic string rand_tag(input exp_t e, input logic [15:0] a, input bit v0);
        if (e.fuse && e.wf) return "R9 random";
        if (e.fuse && a[15:12] == 4'b0111) return "R2 random";
        if (e.fuse && e.asel == 1'b0) return "R3 random";
        if (e.fuse) return "R4 random";
        if (e.wf) return "R8 random";
        if (e.rf) return "R10 random";
        if (!v0) return "R7 random";
        return "R6 random";
    endfunction

    function automatic logic [3:0] rand_opn();
        logic [3:0] t [6] = '{4'b1101, 4'b1001, 4'b1100, 4'b1000, 4'b1011, 4'b0100};
        return t[$urandom % 6];
    endfunction

    // Watchdog: a hung run is a failure but still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        exp_t zero;
        seed = $urandom(32'd20240611);
        zero = '0;
        prev_exp = '0;
        // R1: reset state with a live window on the inputs.
        ins0_i = enc_quick(3'd1, 8'h05); ins1_i = enc_alu(4'b1101, 3'd1, 3'b010, 3'd2, 3'd0);
        val0_i = 1'b1; val1_i = 1'b1;
        repeat (3) @(negedge clk);
        compare(zero, "R1 during reset");
        ins0_i = '0; ins1_i = '0; val0_i = 1'b0; val1_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        compare(zero, "R1 first cycle after reset");

        // R2: quick -1 into D3 then ADD D5,D3.
        apply(enc_quick(3'd3, 8'hFF), enc_alu(4'b1101, 3'd3, 3'b010, 3'd0, 3'd5), 16'h0,
              1, 1, 0, 16'h0, 16'h0, "R2 quick fuse");
        check_bit(a_imm_o == 32'hFFFF_FFFF, 1'b1, "R2 sign extension");
        // R3: long move D1 to D4 then SUB (A2),D4.
        apply(enc_mreg(3'd4, 3'd1), enc_alu(4'b1001, 3'd4, 3'b010, 3'd2, 3'd2), 16'h0,
              1, 1, 0, 16'h0, 16'h0, "R3 register fuse");
        check_bit(a_reg_o == 3'd1 && !a_imm_sel_o, 1'b1, "R3 operand register");
        // R4: long immediate into D0 then EOR (A0)+,D0.
        apply(enc_mimm(3'd0), enc_alu(4'b1011, 3'd0, 3'b010, 3'd3, 3'd0), 16'h0,
              1, 1, 0, 16'h1234, 16'h5678, "R4 immediate fuse");
        check_bit(a_imm_o == 32'h1234_5678 && op_o == 3'd5, 1'b1, "R4 immediate value");
        // R5: unsupported nibble blocks fusion.
        apply(enc_quick(3'd2, 8'h10), enc_alu(4'b0100, 3'd2, 3'b010, 3'd2, 3'd1), 16'h0,
              1, 1, 0, 16'h0, 16'h0, "R5 blocked opcode");
        // R6: register mismatch and self-referencing ea.
        apply(enc_quick(3'd2, 8'h10), enc_alu(4'b1101, 3'd3, 3'b010, 3'd2, 3'd1), 16'h0,
              1, 1, 0, 16'h0, 16'h0, "R6 register mismatch");
        apply(enc_quick(3'd2, 8'h10), enc_alu(4'b1100, 3'd2, 3'b010, 3'd0, 3'd2), 16'h0,
              1, 1, 0, 16'h0, 16'h0, "R6 ea is Dn");
        // R7: invalid slots.
        apply(enc_quick(3'd2, 8'h10), enc_alu(4'b1101, 3'd2, 3'b010, 3'd2, 3'd1), 16'h0,
              1, 0, 0, 16'h0, 16'h0, "R7 second slot invalid");
        check_bit(slots_o == 2'd1, 1'b1, "R7 one slot");
        apply(enc_quick(3'd2, 8'h10), enc_alu(4'b1101, 3'd2, 3'b010, 3'd2, 3'd1), 16'h0,
              0, 1, 0, 16'h0, 16'h0, "R7 first slot invalid");
        check_bit(slots_o == 2'd0, 1'b1, "R7 zero slots");
        // R8: ADD (A1),D6 then store D6 to (A3).
        apply(enc_alu(4'b1101, 3'd6, 3'b010, 3'd2, 3'd1), enc_store(3'd6, 3'd2, 3'd3), 16'h0,
              1, 1, 0, 16'h0, 16'h0, "R8 store forward");
        check_bit(wr_fwd_o, 1'b1, "R8 flag");
        // R9: fused pair plus store of the destination.
        apply(enc_quick(3'd1, 8'h80), enc_alu(4'b1000, 3'd1, 3'b010, 3'd5, 3'd4),
              enc_store(3'd1, 3'd4, 3'd7), 1, 1, 1, 16'h0, 16'h0, "R9 fuse and store");
        check_bit(fuse_o && wr_fwd_o && slots_o == 2'd2, 1'b1, "R9 both in one cycle");
        apply(enc_quick(3'd1, 8'h80), enc_alu(4'b1000, 3'd1, 3'b010, 3'd5, 3'd4),
              enc_store(3'd2, 3'd4, 3'd7), 1, 1, 1, 16'h0, 16'h0, "R9 store other register");
        // R10: load (A0) into D2 then ADD D2,(A1).
        apply(enc_load(3'd2, 3'd2, 3'd0), enc_alu(4'b1101, 3'd2, 3'b110, 3'd2, 3'd1), 16'h0,
              1, 1, 0, 16'h0, 16'h0, "R10 read forward");
        check_bit(rd_fwd_o && !fuse_o, 1'b1, "R10 flag");

        // Constrained random windows.
        for (int i = 0; i < 3000; i++) begin
            logic [2:0]  r, r2;
            logic [15:0] a, b, c;
            bit v0, v1, v2;
            exp_t e;
            r  = 3'($urandom);
            r2 = ($urandom % 4 != 0) ? r : 3'($urandom);
            case ($urandom % 6)
                0: a = enc_quick(r, 8'($urandom));
                1: a = enc_mreg(r, 3'($urandom));
                2: a = enc_mimm(r);
                3: a = enc_alu(rand_opn(), r, 3'b010, 3'($urandom), 3'($urandom));
                4: a = enc_load(r, 3'($urandom), 3'($urandom));
                default: a = 16'($urandom);
            endcase
            case ($urandom % 4)
                0, 1: b = enc_alu(rand_opn(), r2, 3'b010, 3'($urandom), 3'($urandom));
                2: b = ($urandom % 2) ? enc_store(r2, 3'($urandom), 3'($urandom))
                                      : enc_alu(rand_opn(), r2, 3'b110, 3'($urandom), 3'($urandom));
                default: b = 16'($urandom);
            endcase
            c  = ($urandom % 2) ? enc_store(($urandom % 3 != 0) ? r2 : 3'($urandom),
                                            3'($urandom), 3'($urandom)) : 16'($urandom);
            v0 = ($urandom % 8) != 0;
            v1 = ($urandom % 8) != 0;
            v2 = ($urandom % 4) != 0;
            e  = model(a, b, c, v0, v1, v2, 16'h0, 16'h0);
            apply(a, b, c, v0, v1, v2, 16'($urandom), 16'($urandom),
                  rand_tag(e, a, v0));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule